// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block sits beside a DRAM controller and counts what happens there. It has four 32-bit counters. Counter 0 counts clock cycles and sets the length of a sampling window. Counters 1 to 3 each count one event. A per-counter selection code picks that event from an input vector of single-cycle event strobes. Two extra codes count read-channel or write-channel transactions whose ID passes a shared mask-and-match filter.

Software writes a start value into counter 0 so that the window ends after the wanted number of cycles. It then sets the run bit. When counter 0 rolls over from all ones to zero, every counter freezes for readout and the interrupt line rises. An event counter that rolls over just wraps and keeps counting. Software reads the counters, clears the interrupt flag, and pulses the counter-clear bit to start the next window. All access goes through a simple write strobe with an address and data, and a combinational read port.

Top module: `perf_cnt_bank`

## Requirements
- R1: Addresses 4 to 7 read counters 0 to 3. A write to one of these addresses loads that counter, and the write takes priority over the increment in the same cycle.
- R2: Address 0 is control. Bit 0 is the run enable and reads back. Writing 1 to bit 1 clears all four counters in that cycle, and this clear takes priority over increments. Bit 1 always reads back as 0.
- R3: Counter 0 adds one on every cycle where the bank is running (enabled and not frozen), whatever value its selection register holds.
- R4: Addresses 8 to 11 hold the 8-bit selection codes of counters 0 to 3. For counters 1 to 3, a code below 16 counts cycles where the event input bit with that index is high. Any code other than the filter codes of R5 counts nothing.
- R5: Address 2 holds the filter: match value in bits [15:0] and compare mask in bits [31:16], where a mask bit of 1 means that ID bit is compared. Code 0x41 counts cycles with a read-channel valid whose ID matches on all compared bits. Code 0x42 does the same for the write channel.
- R6: When counter 0 steps from 0xFFFFFFFF to 0, status bit 0 (address 1) and irq_o go high. From the next cycle on, all four counters hold their values.
- R7: When counter 1, 2 or 3 steps past 0xFFFFFFFF it wraps to 0 and keeps counting, and irq_o stays low.
- R8: Writing 1 to status bit 0 clears the flag and irq_o, and counting resumes if the bank is enabled. Writing 0 to that bit leaves the flag unchanged.
- R9: While the enable bit is 0, no counter increments, whatever the event inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| evt_i | input | 16 | Event strobes, one per event index |
| rd_vld_i | input | 1 | Read-channel transaction valid |
| rd_id_i | input | 16 | Read-channel transaction ID |
| wr_vld_i | input | 1 | Write-channel transaction valid |
| wr_id_i | input | 16 | Write-channel transaction ID |
| irq_o | output | 1 | Window-expired interrupt, equal to the status flag |

## Verification
The bench uses the default parameters: 32-bit counters, 16 event lines and 16-bit IDs. Full-width counters would take far too long to reach a rollover by counting alone. The preload path of R1 makes both rollovers reachable within a few cycles: the window expiry of counter 0 and the silent wrap of an event counter. The 16-entry event vector covers both ends of the index range, and the 16-bit ID lets the filter test show masked upper bits being ignored.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
    localparam int NUM_CNT = 4;
    localparam int SEL_W   = 8;
    localparam int ADDR_W  = 4;

    localparam logic [SEL_W-1:0] CODE_RD_FILT = 8'h41;
    localparam logic [SEL_W-1:0] CODE_WR_FILT = 8'h42;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] A_FILT = 4'd2;
    localparam logic [1:0]        PG_CNT = 2'b01;  // addresses 4..7
    localparam logic [1:0]        PG_SEL = 2'b10;  // addresses 8..11
endpackage

// File: rtl/perf_id_filter.sv
module perf_id_filter #(
    parameter int ID_W = 16
) (
    input  logic            vld_i,
    input  logic [ID_W-1:0] id_i,
    input  logic [ID_W-1:0] match_i,
    input  logic [ID_W-1:0] mask_i,
    output logic            hit_o
);
    // compare only the bits whose mask bit is set
    assign hit_o = vld_i && (((id_i ^ match_i) & mask_i) == '0);
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
    import perf_cnt_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               rd_hit_i,
    input  logic               wr_hit_i,
    output logic               hit_o
);
    localparam int IDX_W = $clog2(NUM_EVT);

    always_comb begin
        hit_o = 1'b0;
        if (sel_i < SEL_W'(NUM_EVT)) begin
            hit_o = evt_i[sel_i[IDX_W-1:0]];
        end else if (sel_i == CODE_RD_FILT) begin
            hit_o = rd_hit_i;
        end else if (sel_i == CODE_WR_FILT) begin
            hit_o = wr_hit_i;
        end
    end
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
    import perf_cnt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16,
    parameter int ID_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               rd_vld_i,
    input  logic [ID_W-1:0]    rd_id_i,
    input  logic               wr_vld_i,
    input  logic [ID_W-1:0]    wr_id_i,
    output logic               irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
        logic [NUM_CNT-1:0][SEL_W-1:0] sel;
        logic [ID_W-1:0]               match;
        logic [ID_W-1:0]               mask;
        logic                          en;
        logic                          irq;
    } state_t;

    state_t st_d, st_q;

    logic               rd_hit, wr_hit;
    logic [NUM_CNT-1:0] hit;
    logic               run;
    logic               expire;

    perf_id_filter #(.ID_W(ID_W)) u_rd_filt (
        .vld_i(rd_vld_i), .id_i(rd_id_i),
        .match_i(st_q.match), .mask_i(st_q.mask), .hit_o(rd_hit)
    );
    perf_id_filter #(.ID_W(ID_W)) u_wr_filt (
        .vld_i(wr_vld_i), .id_i(wr_id_i),
        .match_i(st_q.match), .mask_i(st_q.mask), .hit_o(wr_hit)
    );

    // counter 0 is the window timer and ignores its selection
    assign hit[0] = 1'b1;
    for (genvar g = 1; g < NUM_CNT; g++) begin : g_sel
        perf_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
            .sel_i(st_q.sel[g]), .evt_i(evt_i),
            .rd_hit_i(rd_hit), .wr_hit_i(wr_hit), .hit_o(hit[g])
        );
    end

    assign run    = st_q.en && !st_q.irq;
    assign expire = run && (st_q.cnt[0] == CNT_MAX);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (run && hit[i]) st_d.cnt[i] = st_q.cnt[i] + 1'b1;
        end
        if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                st_d.en = wr_data[0];
                if (wr_data[1]) st_d.cnt = '0;
            end else if (wr_addr == A_STAT) begin
                if (wr_data[0]) st_d.irq = 1'b0;
            end else if (wr_addr == A_FILT) begin
                st_d.match = wr_data[ID_W-1:0];
                st_d.mask  = wr_data[16 +: ID_W];
            end else if (wr_addr[3:2] == PG_CNT) begin
                st_d.cnt[wr_addr[1:0]] = wr_data;
            end else if (wr_addr[3:2] == PG_SEL) begin
                st_d.sel[wr_addr[1:0]] = wr_data[SEL_W-1:0];
            end
        end
        if (expire) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)              rd_data[0] = st_q.en;
        else if (rd_addr == A_STAT)         rd_data[0] = st_q.irq;
        else if (rd_addr == A_FILT)         rd_data = {st_q.mask, st_q.match};
        else if (rd_addr[3:2] == PG_CNT)    rd_data = st_q.cnt[rd_addr[1:0]];
        else if (rd_addr[3:2] == PG_SEL)    rd_data[SEL_W-1:0] = st_q.sel[rd_addr[1:0]];
    end

    assign irq_o = st_q.irq;

    AST_CNT0_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en) |=> st_q.cnt[0] == $past(st_q.cnt[0]) + 1'b1);          // R3
    AST_EXPIRY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.cnt[0] == CNT_MAX && !wr_en) |=> irq_o);                   // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en) |=> $stable(st_q.cnt));                               // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(st_q.cnt[0]) == CNT_MAX);                        // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !wr_en) |=> $stable(st_q.cnt));                            // R9
endmodule

// File: tb/perf_cnt_bank_tb.sv
module perf_cnt_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] evt_i = '0;
    logic        rd_vld_i = 1'b0;
    logic [15:0] rd_id_i = '0;
    logic        wr_vld_i = 1'b0;
    logic [15:0] wr_id_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_cnt_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_i(evt_i), .rd_vld_i(rd_vld_i), .rd_id_i(rd_id_i),
        .wr_vld_i(wr_vld_i), .wr_id_i(wr_id_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  sel;
        logic [15:0] evt;
        logic        rv;
        logic [15:0] rid;
        logic        wv;
        logic [15:0] wid;
        logic [7:0]  cyc;
        logic [31:0] exp_cnt;
    } vec_t;

    // filter: mask 0x00FF, match 0x0012
    localparam vec_t TBL [9] = '{
        '{8'h03, 16'h0008, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd5, 32'd5}, // R4 event 3
        '{8'h03, 16'hFFF7, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd4, 32'd0}, // R4 other bits
        '{8'h0F, 16'h8000, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd7, 32'd7}, // R4 top index
        '{8'h30, 16'hFFFF, 1'b1, 16'h0012, 1'b1, 16'h0012, 8'd4, 32'd0}, // R4 unused code
        '{8'h41, 16'h0000, 1'b1, 16'h0012, 1'b0, 16'h0000, 8'd4, 32'd4}, // R5 read exact
        '{8'h41, 16'h0000, 1'b1, 16'hAB12, 1'b0, 16'h0000, 8'd6, 32'd6}, // R5 masked bits
        '{8'h41, 16'h0000, 1'b1, 16'h0013, 1'b0, 16'h0000, 8'd3, 32'd0}, // R5 mismatch
        '{8'h42, 16'h0000, 1'b1, 16'h0012, 1'b1, 16'h7712, 8'd3, 32'd3}, // R5 write
        '{8'h42, 16'h0000, 1'b1, 16'h0012, 1'b0, 16'h0012, 8'd3, 32'd0}  // R5 no write vld
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // clear + enable, run cyc increments, disable
    task automatic run_window(input int cyc);
        wr(4'd0, 32'h3);
        repeat (cyc - 1) @(negedge clk);
        wr(4'd0, 32'h0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(4'd0, v); check("R2 reset ctrl", v, 32'h0);
        rd(4'd1, v); check("R6 reset status", v, 32'h0);
        check("R6 reset irq", {31'b0, irq_o}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(4 + i), v); check("R1 reset counter", v, 32'h0);
        end

        wr(4'd2, 32'h00FF_0012);
        rd(4'd2, v); check("R5 filter readback", v, 32'h00FF_0012);
        wr(4'd8, 32'h41);  // counter 0 selection must not matter

        // table walk
        for (int k = 0; k < 9; k++) begin
            evt_i = TBL[k].evt; rd_vld_i = TBL[k].rv; rd_id_i = TBL[k].rid;
            wr_vld_i = TBL[k].wv; wr_id_i = TBL[k].wid;
            wr(4'd9, {24'b0, TBL[k].sel});
            run_window(int'(TBL[k].cyc));
            rd(4'd5, v); check(TBL[k].sel[6] ? "R5 filtered count" : "R4 event count", v, TBL[k].exp_cnt);
            rd(4'd4, v); check("R3 cycle count", v, 32'({24'b0, TBL[k].cyc}));
        end
        evt_i = '0; rd_vld_i = 0; wr_vld_i = 0;

        // R9: disabled, events present
        evt_i = 16'hFFFF;
        wr(4'd9, 32'h0);
        repeat (5) @(negedge clk);
        rd(4'd4, v); check("R9 cnt0 idle", v, 32'd3);
        rd(4'd5, v); check("R9 cnt1 idle", v, 32'd0);
        evt_i = '0;

        // R2 clear bit reads zero, clears counters
        wr(4'd0, 32'h2);
        rd(4'd0, v); check("R2 ctrl readback", v, 32'h0);
        rd(4'd4, v); check("R2 clear cnt0", v, 32'h0);

        // R7 wrap of counter 2
        wr(4'd10, 32'h0);
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, v); check("R1 preload", v, 32'hFFFF_FFFF);
        evt_i = 16'h0001;
        wr(4'd0, 32'h1);
        @(negedge clk);
        wr(4'd0, 32'h0);
        rd(4'd6, v); check("R7 wrapped value", v, 32'd1);
        check("R7 no irq", {31'b0, irq_o}, 32'h0);

        // R6 expiry and freeze
        wr(4'd2 + 4'd2, 32'hFFFF_FFFD); // counter 0 at address 4
        wr(4'd5, 32'h0);
        wr(4'd9, 32'h3);
        evt_i = 16'h0008;
        wr(4'd0, 32'h1);
        repeat (10) @(negedge clk);
        check("R6 irq", {31'b0, irq_o}, 32'h1);
        rd(4'd1, v); check("R6 status", v, 32'h1);
        rd(4'd4, v); check("R6 cnt0 at zero", v, 32'h0);
        rd(4'd5, v); check("R6 cnt1 frozen", v, 32'd3);

        // R8 write 0 keeps flag
        wr(4'd1, 32'h0);
        check("R8 w0 keeps flag", {31'b0, irq_o}, 32'h1);
        rd(4'd5, v); check("R8 still frozen", v, 32'd3);
        // R8 W1C releases: cleared at edge, then 2 more counted edges
        wr(4'd1, 32'h1);
        check("R8 cleared", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        wr(4'd0, 32'h0);
        rd(4'd5, v); check("R8 resumed", v, 32'd5);
        rd(4'd4, v); check("R8 cnt0 resumed", v, 32'd2);

        // R1 write priority over increment
        wr(4'd0, 32'h1);
        wr(4'd5, 32'h0000_0100);
        wr(4'd0, 32'h0);
        rd(4'd5, v); check("R1 write wins", v, 32'h0000_0101);
        evt_i = '0;

        finish_run();
    end
endmodule